// File: doc/BRIEF.md
# Owner-Based Node Coherence Controller

This controller sits between the processors of one node and a single shared bus joining several such nodes. It keeps a small set-associative store of items, each slot holding a tag, a data word and one of four coherence states: Invalid, Shared (a copy whose owner is elsewhere), Master (owner while other copies may exist) and Exclusive (the only copy anywhere). Local reads that hit return data at once. A local read that misses makes the controller ask for the bus, put a read request on it once granted, and then watch incoming traffic for the data reply that carries the same item identifier. The item is then installed as Shared.

The controller also snoops read requests from other nodes. If it owns the item (Exclusive or Master), it queues a reply, asks for the bus and sends the data. An Exclusive owner drops to Master when it answers, because a second copy now exists. A local allocate operation creates an item as Exclusive. When a set is full, the slot to replace is the one whose state ranks lowest in the order Invalid, Shared, Master, Exclusive. Ties go to the lowest way.

Top module: `owner_node_ctrl`

## Requirements
- R1: After reset every slot is Invalid, `bus_req`, `tx_valid` and `lresp_valid` are low, `lreq_ready` is high, and a snooped read of any item draws no reply.
- R2: A local read (`lreq_alloc`=0) that hits a slot in Shared, Master or Exclusive state raises `lresp_valid` with the stored word on the next cycle and does not raise `bus_req`.
- R3: A local read miss raises `bus_req` on the next cycle and holds it until `bus_gnt`. In the granted cycle `tx_valid`=1, `tx_kind`=0 (read request) and `tx_id` is the missed item.
- R4: While a miss is outstanding, only a snooped transfer with `rx_kind`=1 (data) and `rx_id` equal to the missed item completes it. On the next cycle `lresp_valid`=1 with `rx_data`, and the item is installed as Shared. Any other traffic leaves the miss pending.
- R5: A Shared slot never answers a snooped read.
- R6: A snooped read (`rx_kind`=0) hitting an Exclusive slot raises `bus_req` on the next cycle. On grant the block sends `tx_kind`=1 with the item and its data, and the slot becomes Master.
- R7: A Master slot answers every snooped read of its item in the same way.
- R8: When a slot is needed and the item is absent, the victim is the slot with the lowest-ranked state (Invalid < Shared < Master < Exclusive). Among equal ranks the lowest way index is chosen. With `SETS` sets, the set is `id % SETS`.
- R9: A local allocate (`lreq_alloc`=1) writes `lreq_data` into the item's slot, or into a victim slot if the item is absent, and marks it Exclusive.
- R10: While a miss is outstanding `lreq_ready` is low and local requests are ignored.
- R11: When a reply and the node's own read request are both waiting, the grant goes to the reply first. The read request follows on the next granted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_valid | input | 1 | Local request present |
| lreq_alloc | input | 1 | 1 = allocate as Exclusive, 0 = read |
| lreq_id | input | ID_W | Local item identifier |
| lreq_data | input | DATA_W | Data for allocate |
| lreq_ready | output | 1 | Local port accepts requests |
| lresp_valid | output | 1 | Local read data valid |
| lresp_data | output | DATA_W | Local read data |
| bus_req | output | 1 | Bus request |
| bus_gnt | input | 1 | Bus grant |
| tx_valid | output | 1 | Transfer driven this cycle |
| tx_kind | output | 1 | 0 read request, 1 data reply |
| tx_id | output | ID_W | Transfer item identifier |
| tx_data | output | DATA_W | Reply data |
| rx_valid | input | 1 | Snooped transfer present |
| rx_kind | input | 1 | 0 read request, 1 data reply |
| rx_id | input | ID_W | Snooped item identifier |
| rx_data | input | DATA_W | Snooped data |

## Verification
The bench builds the block with two sets of two ways, 6-bit identifiers and 16-bit data. Every even item then contends for the same two slots, so a few allocates and misses bring each replacement ranking within reach: Invalid over Exclusive, Shared over Master, Master over Exclusive, and the lowest-way tie between two Masters and between two Exclusives. Replacement choices are observed at the ports, by whether a later snooped read of each item draws a reply. The same small geometry lets a reply to a snoop collide with a pending miss, which exercises the grant ordering.

// File: rtl/owner_node_ctrl.sv
module owner_node_ctrl #(
  parameter int ID_W   = 8,
  parameter int DATA_W = 32,
  parameter int SETS   = 4,
  parameter int WAYS   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lreq_valid,
  input  logic              lreq_alloc,
  input  logic [ID_W-1:0]   lreq_id,
  input  logic [DATA_W-1:0] lreq_data,
  output logic              lreq_ready,
  output logic              lresp_valid,
  output logic [DATA_W-1:0] lresp_data,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              tx_valid,
  output logic              tx_kind,
  output logic [ID_W-1:0]   tx_id,
  output logic [DATA_W-1:0] tx_data,
  input  logic              rx_valid,
  input  logic              rx_kind,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [DATA_W-1:0] rx_data
);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ID_W - IDX_W;
  localparam int SLOTS = SETS * WAYS;
  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_M = 2'd2, ST_E = 2'd3;

  typedef enum logic [1:0] {IDLE, REQ, WAIT} fsm_t;

  logic [TAG_W-1:0]  tag_q [SLOTS];
  logic [1:0]        st_q  [SLOTS];
  logic [DATA_W-1:0] dat_q [SLOTS];
  fsm_t              fsm_q;
  logic [ID_W-1:0]   miss_q, rp_id_q;
  logic [DATA_W-1:0] rp_dat_q;
  logic              rpend_q;

  logic [ID_W-1:0]   lk_id;
  logic [WAYS-1:0]   lk_hitv, sn_hitv;
  int                lk_slot, vic_slot, sn_slot;
  logic              lk_hit, sn_hit;

  assign lk_id      = (fsm_q == WAIT) ? miss_q : lreq_id;
  assign lreq_ready = (fsm_q == IDLE);
  assign bus_req    = rpend_q | (fsm_q == REQ);
  assign tx_valid   = bus_gnt & bus_req;
  assign tx_kind    = rpend_q;
  assign tx_id      = rpend_q ? rp_id_q : miss_q;
  assign tx_data    = rpend_q ? rp_dat_q : '0;

  always_comb begin
    logic [2:0] best;
    int base_l, base_s;
    base_l   = int'(lk_id[IDX_W-1:0]) * WAYS;
    base_s   = int'(rx_id[IDX_W-1:0]) * WAYS;
    lk_hit   = 1'b0;
    sn_hit   = 1'b0;
    lk_slot  = base_l;
    sn_slot  = base_s;
    vic_slot = base_l;
    best     = 3'd4;
    for (int w = 0; w < WAYS; w++) begin
      lk_hitv[w] = (st_q[base_l+w] != ST_I) && (tag_q[base_l+w] == lk_id[ID_W-1:IDX_W]);
      sn_hitv[w] = (st_q[base_s+w] != ST_I) && (tag_q[base_s+w] == rx_id[ID_W-1:IDX_W]);
      if (lk_hitv[w]) begin lk_hit = 1'b1; lk_slot = base_l + w; end
      if (sn_hitv[w]) begin sn_hit = 1'b1; sn_slot = base_s + w; end
      if ({1'b0, st_q[base_l+w]} < best) begin
        best     = {1'b0, st_q[base_l+w]};
        vic_slot = base_l + w;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
        dat_q[i] <= '0;
      end
      fsm_q       <= IDLE;
      miss_q      <= '0;
      rp_id_q     <= '0;
      rp_dat_q    <= '0;
      rpend_q     <= 1'b0;
      lresp_valid <= 1'b0;
      lresp_data  <= '0;
    end else begin
      lresp_valid <= 1'b0;
      if (tx_valid) begin
        if (rpend_q) rpend_q <= 1'b0;
        else         fsm_q   <= WAIT;
      end
      if (rx_valid && !rx_kind && sn_hit && st_q[sn_slot][1] && !rpend_q) begin
        rpend_q  <= 1'b1;
        rp_id_q  <= rx_id;
        rp_dat_q <= dat_q[sn_slot];
        st_q[sn_slot] <= ST_M;
      end
      case (fsm_q)
        IDLE: if (lreq_valid) begin
          if (lreq_alloc) begin
            tag_q[lk_hit ? lk_slot : vic_slot] <= lreq_id[ID_W-1:IDX_W];
            dat_q[lk_hit ? lk_slot : vic_slot] <= lreq_data;
            st_q[lk_hit ? lk_slot : vic_slot]  <= ST_E;
          end else if (lk_hit) begin
            lresp_valid <= 1'b1;
            lresp_data  <= dat_q[lk_slot];
          end else begin
            miss_q <= lreq_id;
            fsm_q  <= REQ;
          end
        end
        WAIT: if (rx_valid && rx_kind && rx_id == miss_q) begin
          tag_q[vic_slot] <= miss_q[ID_W-1:IDX_W];
          dat_q[vic_slot] <= rx_data;
          st_q[vic_slot]  <= ST_S;
          lresp_valid     <= 1'b1;
          lresp_data      <= rx_data;
          fsm_q           <= IDLE;
        end
        default: ;
      endcase
    end
  end

  // R3
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req);
  // R4
  fill_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_q == WAIT && rx_valid && rx_kind && rx_id == miss_q) |=> lresp_valid && lreq_ready);
  // R10
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lreq_ready |-> !lresp_valid);
  // R8
  single_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hitv) && $onehot0(sn_hitv));
  // R6
  reply_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rpend_q) |-> $past(rx_valid && !rx_kind));
endmodule

// File: tb/owner_node_ctrl_bench.sv
module owner_node_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ID_W = 6, DATA_W = 16;

  logic clk = 0, rst_n = 0;
  logic lreq_valid = 0, lreq_alloc = 0, bus_gnt = 0, rx_valid = 0, rx_kind = 0;
  logic [ID_W-1:0] lreq_id = 0, rx_id = 0, tx_id;
  logic [DATA_W-1:0] lreq_data = 0, rx_data = 0, lresp_data, tx_data;
  logic lreq_ready, lresp_valid, bus_req, tx_valid, tx_kind;
  int runs = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  owner_node_ctrl #(.ID_W(ID_W), .DATA_W(DATA_W), .SETS(2), .WAYS(2)) u_owner_node_ctrl (
    .clk(clk), .rst_n(rst_n), .lreq_valid(lreq_valid), .lreq_alloc(lreq_alloc),
    .lreq_id(lreq_id), .lreq_data(lreq_data), .lreq_ready(lreq_ready),
    .lresp_valid(lresp_valid), .lresp_data(lresp_data), .bus_req(bus_req),
    .bus_gnt(bus_gnt), .tx_valid(tx_valid), .tx_kind(tx_kind), .tx_id(tx_id),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_kind(rx_kind), .rx_id(rx_id),
    .rx_data(rx_data));

  task automatic tick; @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    runs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic alloc(input int id, input int d);
    lreq_valid = 1; lreq_alloc = 1; lreq_id = ID_W'(id); lreq_data = DATA_W'(d);
    tick; lreq_valid = 0; lreq_alloc = 0;
  endtask

  task automatic read_hit(input int id, input int d, input string tag);
    lreq_valid = 1; lreq_id = ID_W'(id);
    tick; lreq_valid = 0;
    chk({tag, " hit valid"}, 32'(lresp_valid), 1);
    chk({tag, " hit data"}, 32'(lresp_data), 32'(d));
    chk({tag, " no bus_req"}, 32'(bus_req), 0);
  endtask

  task automatic snoop(input int id, input bit answer, input int d, input string tag);
    rx_valid = 1; rx_kind = 0; rx_id = ID_W'(id);
    tick; rx_valid = 0;
    chk({tag, " snoop bus_req"}, 32'(bus_req), 32'(answer));
    if (answer) begin
      bus_gnt = 1; #1;
      chk({tag, " reply kind"}, 32'(tx_valid && tx_kind), 1);
      chk({tag, " reply id"}, 32'(tx_id), 32'(id));
      chk({tag, " reply data"}, 32'(tx_data), 32'(d));
      tick; bus_gnt = 0;
      chk({tag, " req dropped"}, 32'(bus_req), 0);
    end
  endtask

  task automatic do_miss(input int id, input int d, input string tag);
    lreq_valid = 1; lreq_alloc = 0; lreq_id = ID_W'(id);
    tick; lreq_valid = 0;
    chk({tag, " miss bus_req"}, 32'(bus_req), 1);
    bus_gnt = 1; #1;
    chk({tag, " read req"}, 32'({tx_valid, tx_kind}), 32'(2));
    chk({tag, " read id"}, 32'(tx_id), 32'(id));
    tick; bus_gnt = 0;
    rx_valid = 1; rx_kind = 1; rx_id = ID_W'(id); rx_data = DATA_W'(d);
    tick; rx_valid = 0;
    chk({tag, " fill resp"}, 32'(lresp_valid), 1);
    chk({tag, " fill data"}, 32'(lresp_data), 32'(d));
  endtask

  task automatic t_reset;
    chk("R1 bus_req", 32'(bus_req), 0);
    chk("R1 tx_valid", 32'(tx_valid), 0);
    chk("R1 lresp_valid", 32'(lresp_valid), 0);
    chk("R1 lreq_ready", 32'(lreq_ready), 1);
    snoop(2, 0, 0, "R1");
  endtask

  task automatic t_alloc_hit;
    alloc(2, 'hA002);
    read_hit(2, 'hA002, "R9 R2 first");
    alloc(2, 'hB002);
    read_hit(2, 'hB002, "R9 overwrite");
  endtask

  task automatic t_owner;
    snoop(2, 1, 'hB002, "R6 exclusive");
    snoop(2, 1, 'hB002, "R7 master");
    read_hit(2, 'hB002, "R2 master");
  endtask

  task automatic t_miss;
    lreq_valid = 1; lreq_id = 12;
    tick; lreq_valid = 0;
    chk("R10 ready low", 32'(lreq_ready), 0);
    chk("R3 bus_req", 32'(bus_req), 1);
    tick;
    chk("R3 held", 32'(bus_req), 1);
    bus_gnt = 1; #1;
    chk("R3 tx read", 32'({tx_valid, tx_kind}), 2);
    chk("R3 tx id", 32'(tx_id), 12);
    tick; bus_gnt = 0;
    chk("R3 req drop", 32'(bus_req), 0);
    lreq_valid = 1; lreq_alloc = 1; lreq_id = 9; lreq_data = 'h9999;
    tick; lreq_valid = 0; lreq_alloc = 0;
    rx_valid = 1; rx_kind = 1; rx_id = 14; rx_data = 'hDEAD;
    tick;
    chk("R4 wrong id", 32'(lresp_valid), 0);
    rx_kind = 0; rx_id = 12;
    tick;
    chk("R4 wrong kind", 32'(lresp_valid), 0);
    rx_kind = 1; rx_data = 'hC00C;
    tick; rx_valid = 0;
    chk("R4 fill valid", 32'(lresp_valid), 1);
    chk("R4 fill data", 32'(lresp_data), 'hC00C);
    chk("R4 ready back", 32'(lreq_ready), 1);
    read_hit(12, 'hC00C, "R4 R2 shared");
    snoop(12, 0, 0, "R5 shared");
    snoop(9, 0, 0, "R10 ignored alloc");
  endtask

  task automatic t_victim;
    alloc(4, 'h0004);
    snoop(2, 1, 'hB002, "R8 S before M");
    snoop(4, 1, 'h0004, "R8 new E");
    do_miss(12, 'hC0C0, "R8 S evicted");
    snoop(2, 0, 0, "R8 M tie low way");
    snoop(4, 1, 'h0004, "R8 M tie keeps way1");
    alloc(1, 'h0001);
    alloc(3, 'h0003);
    alloc(5, 'h0005);
    snoop(1, 0, 0, "R8 E tie low way");
    snoop(3, 1, 'h0003, "R8 I before E");
    snoop(5, 1, 'h0005, "R8 new in way0");
    alloc(6, 'h0006);
    alloc(8, 'h0008);
    snoop(4, 0, 0, "R8 M before E");
    snoop(6, 1, 'h0006, "R8 E kept");
  endtask

  task automatic t_order;
    alloc(8, 'h0808);
    lreq_valid = 1; lreq_id = 10;
    tick; lreq_valid = 0;
    rx_valid = 1; rx_kind = 0; rx_id = 8;
    tick; rx_valid = 0;
    bus_gnt = 1; #1;
    chk("R11 reply first", 32'(tx_kind), 1);
    chk("R11 reply id", 32'(tx_id), 8);
    chk("R11 reply data", 32'(tx_data), 'h0808);
    tick;
    chk("R11 then read", 32'({tx_valid, tx_kind}), 2);
    chk("R11 read id", 32'(tx_id), 10);
    tick; bus_gnt = 0;
    rx_valid = 1; rx_kind = 1; rx_id = 10; rx_data = 'h1010;
    tick; rx_valid = 0;
    chk("R11 fill", 32'(lresp_data), 'h1010);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; runs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    tick; tick; rst_n = 1; tick;
    t_reset;
    t_alloc_hit;
    t_owner;
    t_miss;
    t_victim;
    t_order;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule